// File: doc/BRIEF.md
# Synchronous Burst Pseudo-SRAM Device Engine

This block is the device side of a clocked pseudo-static RAM that is reached through bursts. A host drives an active-low chip select, an address-valid strobe, a write select, an output enable and two byte enables. A burst opens when the address is captured. The block then waits a programmable number of clocks and moves one 16-bit word per clock, with the address counting up on each word. A WAIT flag tells the host when no word moves. WAIT covers the opening latency and also a short stall each time the burst steps from one 16-word row into the next.

A small side port loads a configuration register that holds two fields: the opening latency and the burst length. The length is 4, 8 or 16 words, or unlimited. The host can freeze a burst at any point by dropping the clock enable. While the burst is frozen it can release the data bus by raising the output enable. Resuming continues from the same word and does not pay the opening latency again. Raising chip select ends the burst at once.

Top module: `psram_burst_slave`

## Requirements
- R1: With `ce_n` low and the engine idle, the first enabled clock edge with `adv_n` low captures `addr` as the burst start and selects a read burst if `we_n` is high, or a write burst if it is low.
- R2: The configuration field `cfg_wdata[3:0]` gives the latency L, and a value of 0 acts as 1. `wait_o` is high for L enabled cycles after the start edge. The first word moves at the L-th enabled edge after the start edge, in the first cycle where `wait_o` is low.
- R3: The field `cfg_wdata[5:4]` selects the burst length: 0 is 4 words, 1 is 8, 2 is 16 and 3 is unlimited. A fixed burst returns to idle after its last word, and from then on `wait_o` and `dq_oe` are low.
- R4: The word address rises by one after each word moved. In an unlimited burst it wraps from the last word of the array back to word 0.
- R5: After a word whose address has low four bits of 15 moves, if the burst goes on, `wait_o` is high for exactly 2 cycles. Transfer then resumes at the next address.
- R6: While `clk_en` is low, the burst state, address and counters hold. When `clk_en` returns high, the burst resumes at the same word with no new latency.
- R7: `dq_oe` is high only during a read transfer cycle with `ce_n` and `oe_n` both low. Raising `oe_n` floats the data without ending the burst. In that case `dq_out` reads as zero.
- R8: An enabled edge with `ce_n` high ends any burst and leaves the engine idle. After that, a new burst needs a fresh `adv_n` strobe.
- R9: On a write word, `lb_n` low stores bits 7:0 and `ub_n` low stores bits 15:8. A byte lane whose enable is high keeps its old contents.
- R10: A `cfg_we` pulse loads `cfg_wdata` on the clock edge whether or not `clk_en` is high. A burst keeps the length and latency it captured at its start edge.
- R11: After reset, `wait_o` and `dq_oe` are low and the configuration holds latency 3 with a 4-word length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Clock enable; low suspends the burst |
| ce_n | input | 1 | Chip select, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Write select, low for write burst |
| oe_n | input | 1 | Output enable, active low |
| lb_n | input | 1 | Low byte enable, active low |
| ub_n | input | 1 | High byte enable, active low |
| addr | input | AW | Burst start word address |
| dq_in | input | 16 | Write data |
| dq_out | output | 16 | Read data, zero when not driven |
| dq_oe | output | 1 | Read data drive enable |
| wait_o | output | 1 | High while no word moves |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_wdata | input | 6 | Configuration value: [5:4] length, [3:0] latency |

## Verification
The bench uses the default parameters: a 64-word array (AW of 6) made of 16-word rows and a 2-cycle row stall. This array is small enough that an unlimited burst passes every row boundary and wraps from the top word to word 0 within a few dozen cycles. The 4-bit latency field covers the zero-as-one case and both short and long latencies. Every read is therefore checked against a model that has seen every write and byte-lane mask.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

  localparam int WORD_W = 16;
  localparam int CFG_W  = 6;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LAT,
    ST_XFER,
    ST_STALL
  } burst_st_e;

  // Packed so that [5:4] is the length select and [3:0] the latency.
  typedef struct packed {
    logic [1:0] len_sel;
    logic [3:0] lat;
  } burst_cfg_t;

  localparam burst_cfg_t CFG_RESET = '{len_sel: 2'd0, lat: 4'd3};

  function automatic logic [4:0] beats_of(input logic [1:0] sel);
    case (sel)
      2'd0:    beats_of = 5'd4;
      2'd1:    beats_of = 5'd8;
      default: beats_of = 5'd16;
    endcase
  endfunction

endpackage

// File: rtl/psram_rst_sync.sv
`timescale 1ns/1ps
module psram_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/psram_cfg_reg.sv
`timescale 1ns/1ps
module psram_cfg_reg
  import psram_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] load_val,
  output burst_cfg_t       cfg
);

  burst_cfg_t cfg_d, cfg_q;

  always_comb begin
    cfg_d = cfg_q;
    if (load) cfg_d = burst_cfg_t'(load_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/psram_word_array.sv
`timescale 1ns/1ps
module psram_word_array
  import psram_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        byte_en,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;
  localparam int LANES = WORD_W / 8;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en && byte_en[g]) lane_q[waddr] <= wdata[8*g +: 8];
    end

    assign rdata[8*g +: 8] = lane_q[raddr];
  end

endmodule

// File: rtl/psram_burst_ctrl.sv
`timescale 1ns/1ps
module psram_burst_ctrl
  import psram_pkg::*;
#(
  parameter int AW        = 6,
  parameter int ROW_BITS  = 4,
  parameter int STALL_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clk_en,
  input  logic          ce_n,
  input  logic          adv_n,
  input  logic          we_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr_in,
  input  burst_cfg_t    cfg,
  output logic [AW-1:0] word_addr,
  output logic          wr_en,
  output logic          wait_o,
  output logic          dq_oe
);

  localparam logic [3:0] STALL_LD = 4'(STALL_CYC);

  burst_st_e     st_d, st_q;
  logic [AW-1:0] addr_d, addr_q;
  logic [3:0]    tmr_d, tmr_q;
  logic [4:0]    cnt_d, cnt_q;
  logic [4:0]    len_d, len_q;
  logic          cont_d, cont_q;
  logic          rd_d, rd_q;
  logic          last_beat;
  logic          row_end;

  assign last_beat = !cont_q && (cnt_q == len_q - 5'd1);
  assign row_end   = &addr_q[ROW_BITS-1:0];

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    tmr_d  = tmr_q;
    cnt_d  = cnt_q;
    len_d  = len_q;
    cont_d = cont_q;
    rd_d   = rd_q;
    if (ce_n) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (!adv_n) begin
            st_d   = ST_LAT;
            addr_d = addr_in;
            rd_d   = we_n;
            tmr_d  = (cfg.lat == 4'd0) ? 4'd1 : cfg.lat;
            cnt_d  = 5'd0;
            len_d  = beats_of(cfg.len_sel);
            cont_d = &cfg.len_sel;
          end
        end
        ST_LAT, ST_STALL: begin
          if (tmr_q == 4'd1) st_d = ST_XFER;
          else               tmr_d = tmr_q - 4'd1;
        end
        ST_XFER: begin
          if (last_beat) begin
            st_d = ST_IDLE;
          end else begin
            addr_d = addr_q + AW'(1);
            cnt_d  = cnt_q + 5'd1;
            if (row_end) begin
              st_d  = ST_STALL;
              tmr_d = STALL_LD;
            end
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      tmr_q  <= 4'd0;
      cnt_q  <= 5'd0;
      len_q  <= 5'd4;
      cont_q <= 1'b0;
      rd_q   <= 1'b1;
    end else if (clk_en) begin
      st_q   <= st_d;
      addr_q <= addr_d;
      tmr_q  <= tmr_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      cont_q <= cont_d;
      rd_q   <= rd_d;
    end
  end

  assign word_addr = addr_q;
  assign wr_en     = clk_en && !ce_n && (st_q == ST_XFER) && !rd_q;
  assign wait_o    = (st_q == ST_LAT) || (st_q == ST_STALL);
  assign dq_oe     = (st_q == ST_XFER) && rd_q && !ce_n && !oe_n;

  assert_start_raises_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ce_n && !adv_n && st_q == ST_IDLE) |=> wait_o);

  assert_ce_ends_burst_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && ce_n) |=> (!wait_o && !dq_oe));

  assert_gated_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clk_en) |=> ($stable(st_q) && $stable(addr_q) && $stable(tmr_q) && $stable(cnt_q)));

  assert_row_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ce_n && st_q == ST_XFER && !last_beat && row_end) |=> (wait_o && st_q == ST_STALL));

  assert_fixed_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_en && !ce_n && st_q == ST_XFER && last_beat) |=> (st_q == ST_IDLE && !wait_o));

endmodule

// File: rtl/psram_burst_slave.sv
`timescale 1ns/1ps
module psram_burst_slave
  import psram_pkg::*;
#(
  parameter int AW        = 6,
  parameter int ROW_BITS  = 4,
  parameter int STALL_CYC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_en,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              lb_n,
  input  logic              ub_n,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] dq_in,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              wait_o,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata
);

  logic              rst_sync_n;
  burst_cfg_t        cfg;
  logic [AW-1:0]     word_addr;
  logic              wr_en;
  logic [WORD_W-1:0] rdata;

  psram_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  psram_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (cfg_we),
    .load_val (cfg_wdata),
    .cfg      (cfg)
  );

  psram_burst_ctrl #(
    .AW        (AW),
    .ROW_BITS  (ROW_BITS),
    .STALL_CYC (STALL_CYC)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .clk_en    (clk_en),
    .ce_n      (ce_n),
    .adv_n     (adv_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .addr_in   (addr),
    .cfg       (cfg),
    .word_addr (word_addr),
    .wr_en     (wr_en),
    .wait_o    (wait_o),
    .dq_oe     (dq_oe)
  );

  psram_word_array #(.AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .byte_en ({~ub_n, ~lb_n}),
    .waddr   (word_addr),
    .wdata   (dq_in),
    .raddr   (word_addr),
    .rdata   (rdata)
  );

  assign dq_out = dq_oe ? rdata : '0;

endmodule

// File: tb/tb_psram_burst_slave.sv
`timescale 1ns/1ps
module tb_psram_burst_slave;

  localparam int AW    = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, clk_en, ce_n, adv_n, we_n, oe_n, lb_n, ub_n, cfg_we;
  logic [AW-1:0] addr;
  logic [15:0]   dq_in, dq_out;
  logic          dq_oe, wait_o;
  logic [5:0]    cfg_wdata;

  psram_burst_slave #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .ce_n(ce_n), .adv_n(adv_n),
    .we_n(we_n), .oe_n(oe_n), .lb_n(lb_n), .ub_n(ub_n), .addr(addr),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .wait_o(wait_o),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata)
  );

  int    n_chk  = 0;
  int    n_fail = 0;
  string tag    = "R11";
  bit    run_chk = 0;
  logic [15:0] wd = 16'h1234;

  // reference model state
  int          m_st, m_addr, m_tmr, m_cnt, m_len;
  bit          m_rd, m_cont;
  logic [5:0]  m_cfg;
  logic [15:0] m_mem [DEPTH];

  task automatic chk(string r, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cfg = 6'h03; m_addr = 0; m_tmr = 0; m_cnt = 0;
    end else begin
      logic [5:0] old_cfg;
      old_cfg = m_cfg;
      if (cfg_we) m_cfg = cfg_wdata;
      if (clk_en) begin
        if (ce_n) m_st = 0;
        else case (m_st)
          0: if (!adv_n) begin
               m_st = 1; m_addr = int'(addr); m_rd = we_n;
               m_tmr = (old_cfg[3:0] == 0) ? 1 : int'(old_cfg[3:0]);
               m_cnt = 0; m_cont = (old_cfg[5:4] == 3);
               m_len = 4 << old_cfg[5:4];
             end
          1, 3: if (m_tmr == 1) m_st = 2; else m_tmr--;
          default: begin
            if (!m_rd) begin
              if (!lb_n) m_mem[m_addr][7:0]  = dq_in[7:0];
              if (!ub_n) m_mem[m_addr][15:8] = dq_in[15:8];
            end
            if (!m_cont && m_cnt == m_len - 1) m_st = 0;
            else begin
              if (m_addr % 16 == 15) begin m_st = 3; m_tmr = 2; end
              m_addr = (m_addr + 1) % DEPTH;
              m_cnt++;
            end
          end
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (run_chk) begin
      bit e_wait, e_oe;
      #1;
      e_wait = (m_st == 1 || m_st == 3);
      e_oe   = (m_st == 2) && m_rd && !oe_n && !ce_n;
      chk(tag, "wait_o", {15'd0, wait_o}, {15'd0, e_wait});
      chk(tag, "dq_oe", {15'd0, dq_oe}, {15'd0, e_oe});
      if (e_oe) chk(tag, "dq_out", dq_out, m_mem[m_addr]);
      else      chk(tag, "dq_out idle", dq_out, 16'h0000);
    end
  end

  task automatic cyc(bit ce, bit adv, bit we, bit oe, bit en = 1,
                     logic [AW-1:0] a = '0, bit lb = 0, bit ub = 0,
                     bit cw = 0, logic [5:0] cv = '0);
    ce_n = ce; adv_n = adv; we_n = we; oe_n = oe; clk_en = en; addr = a;
    lb_n = lb; ub_n = ub; cfg_we = cw; cfg_wdata = cv; dq_in = wd;
    wd = wd * 16'd5 + 16'h03C1;
    @(negedge clk);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 1, 1);
  endtask

  task automatic setcfg(logic [5:0] v);
    cyc(1, 1, 1, 1, 1, '0, 0, 0, 1, v);
  endtask

  task automatic start(bit we, logic [AW-1:0] a);
    cyc(0, 0, we, 1, 1, a);
  endtask

  task automatic run(int n, bit we);
    for (int i = 0; i < n; i++) cyc(0, 1, we, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    rst_n = 0; clk_en = 1; ce_n = 1; adv_n = 1; we_n = 1; oe_n = 1;
    lb_n = 0; ub_n = 0; cfg_we = 0; cfg_wdata = '0; addr = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(3);
    #1;
    chk("R11", "reset wait_o", {15'd0, wait_o}, 16'd0);
    chk("R11", "reset dq_oe", {15'd0, dq_oe}, 16'd0);
    run_chk = 1;

    // R11: default config, 4-word write after latency 3
    tag = "R11"; start(0, 6'd4); run(10, 0); idle(2);

    // R4: unlimited write wraps the whole array
    tag = "R4"; setcfg(6'h32); start(0, 6'd0); run(84, 0); idle(2);

    // R1: read select by we_n high, default-written region
    tag = "R1"; setcfg(6'h01); start(1, 6'd3); run(8, 1); idle(2);

    // R3 / R5 / R2: 8-word read, latency 4, crossing row at 15
    begin
      int w_pre, w_mid, n_oe;
      bit seen;
      w_pre = 0; w_mid = 0; n_oe = 0; seen = 0;
      tag = "R3"; setcfg(6'h14); start(1, 6'd12);
      for (int i = 0; i < 20; i++) begin
        #2;
        if (dq_oe) begin n_oe++; seen = 1; end
        else if (wait_o) begin if (!seen) w_pre++; else w_mid++; end
        cyc(0, 1, 1, 0);
      end
      chk("R2", "latency wait cycles", 16'(w_pre), 16'd4);
      chk("R5", "row stall cycles", 16'(w_mid), 16'd2);
      chk("R3", "fixed 8 word count", 16'(n_oe), 16'd8);
      idle(2);
    end

    // R6: clock-enable suspension mid-burst
    tag = "R6"; setcfg(6'h31); start(1, 6'd20);
    for (int i = 0; i < 18; i++) cyc(0, 1, 1, 0, (i % 3 != 1));
    // R7: output enable toggling while burst continues
    tag = "R7";
    for (int i = 0; i < 16; i++) cyc(0, 1, 1, (i % 5 == 2), (i % 4 != 3));
    // R8: chip select ends burst, no restart without adv_n
    tag = "R8"; cyc(1, 1, 1, 0); run(6, 1); idle(2);

    // R9: byte-lane masked writes then read back
    tag = "R9"; setcfg(6'h22); start(0, 6'd32);
    for (int i = 0; i < 22; i++) cyc(0, 1, 0, 0, 1, '0, i[0], i[1]);
    idle(2);
    start(1, 6'd32); run(22, 1); idle(2);

    // R2: latency field 0 acts as 1
    tag = "R2"; setcfg(6'h00); start(1, 6'd40);
    #2; chk("R2", "lat0 wait after start", {15'd0, wait_o}, 16'd1);
    cyc(0, 1, 1, 0);
    #2; chk("R2", "lat0 first word", {15'd0, dq_oe}, 16'd1);
    run(6, 1); idle(2);

    // R10: config change mid-burst does not alter the running burst
    begin
      int n_oe;
      n_oe = 0;
      tag = "R10"; setcfg(6'h06); start(1, 6'd48);
      cyc(0, 1, 1, 0, 1, '0, 0, 0, 1, 6'h21);
      for (int i = 0; i < 20; i++) begin
        #2; if (dq_oe) n_oe++;
        cyc(0, 1, 1, 0);
      end
      chk("R10", "captured length kept", 16'(n_oe), 16'd4);
      idle(2);
    end

    // R4 / R5: unlimited read wraps 63 -> 0 with a stall
    tag = "R4"; setcfg(6'h31); start(1, 6'd60); run(14, 1); idle(3);

    run_chk = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule